// File: doc/BRIEF.md
# Speculative Memory Disambiguation Buffer

This block sits between a set of concurrently running tasks and a data cache. The tasks occupy slots on a ring, and their program order follows the ring, starting at the head slot. A task's age is its distance from the head around the ring. Stores made by a speculative task, meaning any task other than the head, are kept in the buffer and never reach the cache. The head task writes the cache directly. The exception is an address it already holds in the buffer from its speculative phase: that copy is updated in place. Loads receive the value of the nearest store at the same or an older position, or the cache data when no such store exists.

The buffer also records, per address, which speculative tasks have loaded a value they did not produce themselves. When a store arrives, the buffer looks at the tasks younger than the storing task. If one of them read the address too early, it reports that task so that it and everything after it can be restarted. A squash port discards every record of the selected slots at once. A commit drains the head task's held stores into the cache one per cycle, clears its records and advances the head. When a speculative access would need a fresh entry and none is free, the access is stalled and the requester retries.

Top module: `spec_mem_buffer`

## Requirements
- R1: After reset the head slot is 0, no violation is reported, no request is stalled and no cache write is issued; all 8 entries are free.
- R2: A store from a speculative slot never raises cache_we. A store from the head slot with no buffered copy of its own at that address raises cache_we in the same cycle, with the request address and data.
- R3: A load returns, in the same cycle, the data of the nearest store to that address made by the loading slot or an older slot, and raises ld_fwd. When no such store is held, it returns cache_rdata with ld_fwd low. A head-slot store to an address the head already holds updates the held value instead of writing the cache.
- R4: A store raises viol_valid one cycle later when a younger slot has an exposed load of that address, meaning it loaded the address without first storing to it. viol_slot names the oldest such younger slot. A younger slot that stored to the address, found before any exposed load in age order, shields the slots behind it.
- R5: A commit pulse starts a drain. For each held store of the head slot, one cycle writes it to the cache, lowest entry first. One further cycle then advances head_slot by one, modulo 4. req_stall is high throughout the drain.
- R6: A squash clears all load and store records of the masked slots at the next clock edge. Later loads no longer receive their data, later stores no longer flag their loads, and entries left without records become free.
- R7: A speculative access that needs a new entry while all 8 are in use raises req_stall and changes nothing. Head-slot accesses never stall for capacity.
- R8: Age is measured from the current head around the 4-slot ring, so forwarding and violation order follow the head as it wraps.
- R9: A request from a slot that is being squashed in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_slot | input | 2 | Ring slot of the requesting task |
| req_addr | input | 8 | Access address |
| req_wdata | input | 16 | Store data |
| req_stall | output | 1 | Request not accepted this cycle; retry |
| ld_data | output | 16 | Load result (forwarded or cache) |
| ld_fwd | output | 1 | Load result came from a held store |
| cache_rdata | input | 16 | Cache read data for req_addr |
| cache_we | output | 1 | Cache write strobe |
| cache_waddr | output | 8 | Cache write address |
| cache_wdata | output | 16 | Cache write data |
| commit_valid | input | 1 | Head task has completed; drain it |
| head_slot | output | 2 | Current head slot |
| squash_valid | input | 1 | Squash request |
| squash_mask | input | 4 | Slots to squash, one bit per slot |
| viol_valid | output | 1 | Dependence violation detected |
| viol_slot | output | 2 | First slot to restart |

## Verification
ld_data, ld_fwd, req_stall and the direct-store cache write are combinational and are due in the same cycle as the request. viol_valid and viol_slot register on the edge that accepts the store. A squash or record update is visible to the next request. head_slot moves k+1 cycles after the commit edge, where k is the number of held stores. The bench drives at the falling edge and reads combinational results 5 ns later, before the rising edge. It reads registered results 1 ns after the rising edge. During a drain it reads the cache write port once per cycle at the falling edge and counts cycles until head_slot moves.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic {
        PH_RUN   = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;
endpackage

// File: rtl/smb_lookup.sv
`timescale 1ns/1ps
module smb_lookup
    import smb_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int N_SLOT = 4,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic [N_ENT-1:0][N_SLOT-1:0] ld_i,
    input  logic [N_ENT-1:0][N_SLOT-1:0] st_i,
    input  addr_t                        tag_i [N_ENT],
    input  addr_t                        addr_i,
    input  logic [SLOT_W-1:0]            drain_slot_i,
    output logic                         hit_o,
    output logic [IDX_W-1:0]             hit_idx_o,
    output logic                         free_any_o,
    output logic [IDX_W-1:0]             free_idx_o,
    output logic                         drain_any_o,
    output logic [IDX_W-1:0]             drain_idx_o
);
    logic [N_ENT-1:0] used, match, drn;

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        assign used[e]  = |(ld_i[e] | st_i[e]);
        assign match[e] = used[e] && (tag_i[e] == addr_i);
        assign drn[e]   = st_i[e][drain_slot_i];
    end

    // Lowest index wins for every search
    always_comb begin
        hit_idx_o   = '0;
        free_idx_o  = '0;
        drain_idx_o = '0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (match[e]) hit_idx_o = IDX_W'(e);
            if (!used[e]) free_idx_o = IDX_W'(e);
            if (drn[e]) drain_idx_o = IDX_W'(e);
        end
    end

    assign hit_o       = |match;
    assign free_any_o  = ~&used;
    assign drain_any_o = |drn;
endmodule

// File: rtl/smb_order.sv
`timescale 1ns/1ps
module smb_order #(
    parameter int N_SLOT = 4,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic [SLOT_W-1:0] head_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [N_SLOT-1:0] ld_row_i,
    input  logic [N_SLOT-1:0] st_row_i,
    output logic              own_st_o,
    output logic              fwd_o,
    output logic [SLOT_W-1:0] fwd_slot_o,
    output logic              viol_o,
    output logic [SLOT_W-1:0] viol_slot_o
);
    logic [SLOT_W-1:0] age;
    logic [SLOT_W-1:0] back_cand, fore_cand;
    logic              halted;

    assign age      = slot_i - head_i;
    assign own_st_o = st_row_i[slot_i];

    // Walk toward the head: the nearest store at or before the requester
    always_comb begin
        fwd_o      = 1'b0;
        fwd_slot_o = slot_i;
        back_cand  = slot_i;
        for (int k = 0; k < N_SLOT; k++) begin
            back_cand = slot_i - SLOT_W'(k);
            if (!fwd_o && (k <= int'(age)) && st_row_i[back_cand]) begin
                fwd_o      = 1'b1;
                fwd_slot_o = back_cand;
            end
        end
    end

    // Walk away from the head: first exposed load, unless a store shields it
    always_comb begin
        viol_o      = 1'b0;
        viol_slot_o = slot_i;
        halted      = 1'b0;
        fore_cand   = slot_i;
        for (int k = 1; k < N_SLOT; k++) begin
            fore_cand = slot_i + SLOT_W'(k);
            if (!halted && (k + int'(age) < N_SLOT)) begin
                if (ld_row_i[fore_cand]) begin
                    viol_o      = 1'b1;
                    viol_slot_o = fore_cand;
                    halted      = 1'b1;
                end else if (st_row_i[fore_cand]) begin
                    halted = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spec_mem_buffer.sv
`timescale 1ns/1ps
module spec_mem_buffer
    import smb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_is_store,
    input  logic [SLOT_W-1:0]    req_slot,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_stall,
    output logic [DATA_W-1:0]    ld_data,
    output logic                 ld_fwd,
    input  logic [DATA_W-1:0]    cache_rdata,
    output logic                 cache_we,
    output logic [ADDR_W-1:0]    cache_waddr,
    output logic [DATA_W-1:0]    cache_wdata,
    input  logic                 commit_valid,
    output logic [SLOT_W-1:0]    head_slot,
    input  logic                 squash_valid,
    input  logic [NUM_SLOTS-1:0] squash_mask,
    output logic                 viol_valid,
    output logic [SLOT_W-1:0]    viol_slot
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);

    logic [NUM_ENTRIES-1:0][NUM_SLOTS-1:0] ld_q, st_q;
    addr_t             tag_q [NUM_ENTRIES];
    data_t             val_q [NUM_ENTRIES][NUM_SLOTS];
    logic [SLOT_W-1:0] head_q, viol_slot_q;
    phase_e            phase_q;
    logic              viol_q;

    logic              hit, free_any, drain_any;
    logic [IDX_W-1:0]  hit_idx, free_idx, drain_idx, tgt_idx;
    logic [NUM_SLOTS-1:0] row_ld, row_st;
    logic              own_st, fwd_found, viol_found;
    logic [SLOT_W-1:0] fwd_slot, viol_found_slot;
    logic              busy, is_head, dropped, live, cap_stall, accept;
    logic              keep_store, head_direct, new_load_rec;

    smb_lookup #(.N_ENT(NUM_ENTRIES), .N_SLOT(NUM_SLOTS)) u_lookup (
        .ld_i(ld_q), .st_i(st_q), .tag_i(tag_q), .addr_i(req_addr),
        .drain_slot_i(head_q),
        .hit_o(hit), .hit_idx_o(hit_idx),
        .free_any_o(free_any), .free_idx_o(free_idx),
        .drain_any_o(drain_any), .drain_idx_o(drain_idx)
    );

    assign row_ld = hit ? ld_q[hit_idx] : '0;
    assign row_st = hit ? st_q[hit_idx] : '0;

    smb_order #(.N_SLOT(NUM_SLOTS)) u_order (
        .head_i(head_q), .slot_i(req_slot),
        .ld_row_i(row_ld), .st_row_i(row_st),
        .own_st_o(own_st), .fwd_o(fwd_found), .fwd_slot_o(fwd_slot),
        .viol_o(viol_found), .viol_slot_o(viol_found_slot)
    );

    assign busy      = (phase_q == PH_DRAIN);
    assign is_head   = (req_slot == head_q);
    assign dropped   = squash_valid && squash_mask[req_slot];
    assign live      = req_valid && !dropped && !busy;
    assign cap_stall = live && !is_head && !hit && !free_any;
    assign accept    = live && !cap_stall;
    assign tgt_idx   = hit ? hit_idx : free_idx;

    // Stores kept in the buffer: every speculative one, and head stores to held addresses
    assign keep_store   = accept && req_is_store && (!is_head || row_st[head_q]);
    assign head_direct  = accept && req_is_store && is_head && !row_st[head_q];
    assign new_load_rec = accept && !req_is_store && !is_head && !own_st;

    assign req_stall   = busy || cap_stall;
    assign ld_fwd      = req_valid && !req_is_store && fwd_found;
    assign ld_data     = ld_fwd ? val_q[hit_idx][fwd_slot] : cache_rdata;
    assign cache_we    = busy ? drain_any : head_direct;
    assign cache_waddr = busy ? tag_q[drain_idx] : req_addr;
    assign cache_wdata = busy ? val_q[drain_idx][head_q] : req_wdata;
    assign head_slot   = head_q;
    assign viol_valid  = viol_q;
    assign viol_slot   = viol_slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q        <= '0;
            st_q        <= '0;
            head_q      <= '0;
            phase_q     <= PH_RUN;
            viol_q      <= 1'b0;
            viol_slot_q <= '0;
        end else begin
            viol_q      <= accept && req_is_store && viol_found;
            viol_slot_q <= viol_found_slot;
            if (squash_valid) begin
                for (int e = 0; e < NUM_ENTRIES; e++) begin
                    for (int s = 0; s < NUM_SLOTS; s++) begin
                        if (squash_mask[s]) begin
                            ld_q[e][s] <= 1'b0;
                            st_q[e][s] <= 1'b0;
                        end
                    end
                end
            end
            if (keep_store) st_q[tgt_idx][req_slot] <= 1'b1;
            if (new_load_rec) ld_q[tgt_idx][req_slot] <= 1'b1;
            case (phase_q)
                PH_RUN: if (commit_valid) phase_q <= PH_DRAIN;
                PH_DRAIN: begin
                    if (drain_any) begin
                        st_q[drain_idx][head_q] <= 1'b0;
                    end else begin
                        for (int e = 0; e < NUM_ENTRIES; e++) ld_q[e][head_q] <= 1'b0;
                        head_q  <= head_q + 1'b1;
                        phase_q <= PH_RUN;
                    end
                end
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (keep_store) begin
            if (!hit) tag_q[tgt_idx] <= req_addr;
            val_q[tgt_idx][req_slot] <= req_wdata;
        end
        if (new_load_rec && !hit) tag_q[tgt_idx] <= req_addr;
    end

    // Records still present per slot, for the squash check
    logic [NUM_SLOTS-1:0] live_bits;
    always_comb begin
        live_bits = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) live_bits = live_bits | ld_q[e] | st_q[e];
    end

    assert_spec_store_held_R2: assert property (@(posedge clk) disable iff (rst)
        cache_we |-> (busy || (req_valid && req_is_store && req_slot == head_q)));

    assert_stall_only_spec_R7: assert property (@(posedge clk) disable iff (rst)
        (req_stall && !busy) |-> (req_valid && req_slot != head_q));

    assert_head_moves_after_drain_R5: assert property (@(posedge clk) disable iff (rst)
        (head_q != $past(head_q)) |-> $past(busy));

    assert_viol_follows_store_R4: assert property (@(posedge clk) disable iff (rst)
        viol_valid |-> $past(req_valid && req_is_store && !req_stall));

    assert_squash_clears_R6: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> ((live_bits & $past(squash_mask)) == '0));
endmodule

// File: tb/spec_mem_buffer_tb_top.sv
`timescale 1ns/1ps
module spec_mem_buffer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_is_store;
    logic [1:0]  req_slot;
    logic [7:0]  req_addr;
    logic [15:0] req_wdata;
    logic        req_stall, ld_fwd, cache_we;
    logic [15:0] ld_data, cache_rdata, cache_wdata;
    logic [7:0]  cache_waddr;
    logic        commit_valid, squash_valid, viol_valid;
    logic [1:0]  head_slot, viol_slot;
    logic [3:0]  squash_mask;

    int checks = 0;
    int errors = 0;
    int hd = 0;

    logic        o_stall, o_fwd, o_we;
    logic [15:0] o_ld, o_wd;
    logic [7:0]  o_wa;
    logic [7:0]  wr_a [8];
    logic [15:0] wr_d [8];
    int          n_wr, n_busy;

    always #10 clk = ~clk;
    assign cache_rdata = {8'hCA, req_addr};

    spec_mem_buffer dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_is_store(req_is_store), .req_slot(req_slot),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_stall(req_stall),
        .ld_data(ld_data), .ld_fwd(ld_fwd), .cache_rdata(cache_rdata),
        .cache_we(cache_we), .cache_waddr(cache_waddr), .cache_wdata(cache_wdata),
        .commit_valid(commit_valid), .head_slot(head_slot),
        .squash_valid(squash_valid), .squash_mask(squash_mask),
        .viol_valid(viol_valid), .viol_slot(viol_slot)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int age(input int s, input int h);
        return (s - h + 4) % 4;
    endfunction

    task automatic idle();
        req_valid = 0; req_is_store = 0; req_slot = 0; req_addr = 0; req_wdata = 0;
        commit_valid = 0; squash_valid = 0; squash_mask = 0;
    endtask

    task automatic access(input int sl, input bit st, input logic [7:0] a,
                          input logic [15:0] d, input logic [3:0] sq);
        @(negedge clk);
        req_valid = 1; req_is_store = st; req_slot = 2'(sl); req_addr = a; req_wdata = d;
        squash_valid = (sq != 0); squash_mask = sq;
        #5;
        o_stall = req_stall; o_ld = ld_data; o_fwd = ld_fwd;
        o_we = cache_we; o_wa = cache_waddr; o_wd = cache_wdata;
        @(posedge clk); #1;
        idle();
    endtask

    task automatic squash(input logic [3:0] m);
        @(negedge clk);
        squash_valid = 1; squash_mask = m;
        @(posedge clk); #1;
        idle();
    endtask

    task automatic cleanup();
        squash(4'hF & ~(4'b1 << hd));
    endtask

    task automatic commit();
        logic [1:0] old;
        old = head_slot;
        n_wr = 0; n_busy = 0;
        @(negedge clk);
        commit_valid = 1;
        @(posedge clk); #1;
        commit_valid = 0;
        while (head_slot == old && n_busy < 50) begin
            @(negedge clk);
            chk("R5 stall during drain", req_stall, 1);
            if (cache_we && n_wr < 8) begin
                wr_a[n_wr] = cache_waddr; wr_d[n_wr] = cache_wdata; n_wr++;
            end
            @(posedge clk); #1;
            n_busy++;
        end
        hd = (hd + 1) % 4;
        chk("R5 head advance", head_slot, hd);
    endtask

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 head", head_slot, 0);
        chk("R1 viol", viol_valid, 0);
        chk("R1 stall", req_stall, 0);
        chk("R1 cache_we", cache_we, 0);

        // R2/R3/R4/R8 sweep over every head, store slot and load slot
        for (int h = 0; h < 4; h++) begin
            for (int s = 0; s < 4; s++) begin
                for (int l = 0; l < 4; l++) begin
                    logic [15:0] d;
                    bit ef, ev;
                    d = 16'h1000 + 16'(s * 16 + l + h * 256);
                    access(s, 1, 8'h20, d, 0);
                    chk("R2 store cache write", o_we, (s == hd));
                    if (s == hd) begin
                        chk("R2 direct addr", o_wa, 8'h20);
                        chk("R2 direct data", o_wd, d);
                    end
                    access(l, 0, 8'h20, 0, 0);
                    ef = (s != hd) && (age(s, hd) <= age(l, hd));
                    chk("R3 R8 fwd flag", o_fwd, ef);
                    chk("R3 R8 load data", o_ld, ef ? d : 16'hCA20);
                    chk("R4 no viol store-then-load", viol_valid, 0);
                    cleanup();
                    access(l, 0, 8'h30, 0, 0);
                    access(s, 1, 8'h30, d, 0);
                    ev = (l != hd) && (age(l, hd) > age(s, hd));
                    chk("R4 R8 viol", viol_valid, ev);
                    if (ev) chk("R4 viol slot", viol_slot, l);
                    cleanup();
                end
            end
            commit();
            chk("R5 empty drain cycles", n_busy, 1);
        end

        // R4 shielding and nearest exposed load, head 0
        access(2, 1, 8'h40, 16'h2222, 0);
        access(3, 0, 8'h40, 0, 0);
        chk("R3 fwd from older", o_ld, 16'h2222);
        access(1, 1, 8'h40, 16'h1111, 0);
        chk("R4 shielded", viol_valid, 0);
        access(3, 0, 8'h50, 0, 0);
        access(2, 0, 8'h50, 0, 0);
        access(1, 1, 8'h50, 16'h1212, 0);
        chk("R4 viol nearest", viol_valid, 1);
        chk("R4 viol slot nearest", viol_slot, 2);
        cleanup();

        // R5 drain of held stores, head-own forwarding and in-place update
        access(1, 1, 8'h61, 16'h00A1, 0);
        access(1, 1, 8'h62, 16'h00A2, 0);
        access(1, 1, 8'h63, 16'h00A3, 0);
        commit();
        chk("R5 empty drain cycles", n_busy, 1);
        access(1, 0, 8'h62, 0, 0);
        chk("R3 head own fwd", o_ld, 16'h00A2);
        access(1, 1, 8'h62, 16'h00B2, 0);
        chk("R3 head held update no cache write", o_we, 0);
        commit();
        chk("R5 drain cycles", n_busy, 4);
        chk("R5 write count", n_wr, 3);
        chk("R5 w0 addr", wr_a[0], 8'h61); chk("R5 w0 data", wr_d[0], 16'h00A1);
        chk("R5 w1 addr", wr_a[1], 8'h62); chk("R5 w1 data", wr_d[1], 16'h00B2);
        chk("R5 w2 addr", wr_a[2], 8'h63); chk("R5 w2 data", wr_d[2], 16'h00A3);
        access(2, 0, 8'h61, 0, 0);
        chk("R5 drained not forwarded", o_fwd, 0);
        chk("R5 drained load data", o_ld, 16'hCA61);

        // R7 capacity, head 2
        for (int i = 0; i < 8; i++) begin
            access(3, 1, 8'h80 + 8'(i), 16'h5000 + 16'(i), 0);
            chk("R1 R7 fill no stall", o_stall, 0);
        end
        access(3, 1, 8'h88, 16'h5555, 0);
        chk("R7 full store stall", o_stall, 1);
        access(0, 0, 8'h88, 0, 0);
        chk("R7 full load stall", o_stall, 1);
        access(3, 0, 8'h81, 0, 0);
        chk("R7 own held load no stall", o_stall, 0);
        chk("R7 own held load data", o_ld, 16'h5001);
        access(2, 0, 8'h88, 0, 0);
        chk("R7 stalled store left nothing", o_fwd, 0);
        chk("R7 head load no stall", o_stall, 0);
        access(2, 1, 8'h88, 16'h7777, 0);
        chk("R7 head store no stall", o_stall, 0);
        chk("R7 head store cache write", o_we, 1);
        squash(4'b1000);
        access(0, 1, 8'h88, 16'h6666, 0);
        chk("R6 squash frees entries", o_stall, 0);
        cleanup();

        // R6/R9 squash behaviour, head 2
        access(3, 1, 8'h90, 16'h3333, 0);
        access(0, 1, 8'h91, 16'h4444, 4'b0001);
        access(0, 0, 8'h91, 0, 0);
        chk("R9 dropped store fwd", o_fwd, 0);
        chk("R9 dropped store data", o_ld, 16'hCA91);
        squash(4'b1000);
        access(0, 0, 8'h90, 0, 0);
        chk("R6 squashed store not fwd", o_fwd, 0);
        squash(4'b0001);
        access(3, 1, 8'h90, 16'h3434, 0);
        chk("R6 squashed load no viol", viol_valid, 0);
        cleanup();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule